// File: doc/BRIEF.md
# Two-Level Block Frame Address Walker

This block produces the address stream for one transfer channel that copies a frame made of a rectangular grid of 2D blocks. All quantities are counted in 128-bit words. It keeps two address tracks, one for system memory and one for a local buffer. Each track has its own line stride. Both tracks share a signed horizontal step between block columns and a signed vertical step between block rows. The vertical step is counted in lines, so on each side it is multiplied by that side's line stride.

The walk visits the blocks in raster order, moving along a row first and then down. Inside a block it covers every line from top to bottom and cuts each line into bursts. A burst never exceeds the configured maximum, and the last burst of a line takes whatever words remain. A burst is offered with a valid/ready handshake. The block pulses a block-done flag after every 2D block and a frame-done flag after the whole frame. It also reports the grid coordinates of the most recently finished block.

The controller has four states:
- `ST_IDLE` goes to `ST_BURST` on `start`.
- `ST_BURST` stays put until the final burst of a block's final line is accepted, then goes to `ST_BLK_END`.
- `ST_BLK_END` goes back to `ST_BURST` for the next block, or to `ST_FRM_END` after the last block.
- `ST_FRM_END` always returns to `ST_IDLE`.

Top module: `blk2d_walker`

## Requirements
- R1: After reset, `bst_valid`, `blk_done`, `frm_done` and `busy` are 0, and `last_bx`/`last_by` are 0.
- R2: A `start` seen while idle captures every configuration input. `bst_valid` is 1 in the following cycle, and the first burst carries `sys_base` and `loc_base`.
- R3: `bst_len` equals min(2^`cfg_burst_code`, words left in the line). Codes 0,1,2,3 mean caps of 1,2,4,8 words.
- R4: Within a line, each new burst address on each side is the previous burst address plus the previous `bst_len`.
- R5: Line l of a block starts at that block's start address plus l × the side's line stride (16-bit system stride, 20-bit local stride).
- R6: Block (bx,by), visited with bx varying fastest, starts at base + bx·xstep + by·ystep·stride on each side. xstep is 11-bit two's complement, ystep is 14-bit two's complement, and arithmetic wraps modulo the side's address width (28 bits system, 20 bits local).
- R7: `blk_done` is a one-cycle pulse in the cycle after the last burst of a block is accepted. In that cycle `last_bx`/`last_by` hold that block's coordinates, and they keep them until the next block finishes.
- R8: `frm_done` is a one-cycle pulse in the cycle after the final `blk_done`. `busy` is 0 in the cycle after that.
- R9: `start` pulses and configuration input changes during a walk have no effect on the ongoing address sequence.
- R10: An accepted `start` clears `last_bx` and `last_by` to 0 in the following cycle.
- R11: While `bst_valid` is 1 and `bst_ready` is 0, the burst addresses and length stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame walk (taken only when idle) |
| cfg_sys_base | input | 28 | System-side frame base, words |
| cfg_loc_base | input | 20 | Local-side frame base, words |
| cfg_sys_stride | input | 16 | System-side line stride, words |
| cfg_loc_stride | input | 20 | Local-side line stride, words |
| cfg_blk_w | input | 10 | Block width in words, 1..1023 |
| cfg_blk_h | input | 13 | Block height in lines, 1..8191 |
| cfg_cols | input | 10 | Blocks per row, 1..1023 |
| cfg_rows | input | 10 | Block rows, 1..1023 |
| cfg_xstep | input | 11 | Signed column step, words |
| cfg_ystep | input | 14 | Signed row step, lines |
| cfg_burst_code | input | 2 | Burst cap code (1,2,4,8 words) |
| bst_ready | input | 1 | Burst accepted by downstream |
| bst_valid | output | 1 | Burst offered |
| bst_sys_addr | output | 28 | System-side burst address |
| bst_loc_addr | output | 20 | Local-side burst address |
| bst_len | output | 4 | Burst length in words |
| blk_done | output | 1 | One-cycle pulse after each block |
| frm_done | output | 1 | One-cycle pulse after the frame |
| busy | output | 1 | Walk in progress |
| last_bx | output | 10 | Column of last finished block |
| last_by | output | 10 | Row of last finished block |

## Verification
The assertions take for granted that the width, height and grid counts are never zero while a walk runs. They also assume `rst_n` is released between clock edges. The stimulus drives only counts of 1 or more, and it varies `bst_ready` in three ways: always high, toggling, and pseudo-random. Some walks deliberately scramble the configuration inputs and pulse `start` while a frame is under way. Those walks check that only the values captured at the first `start` shape the sequence.

// File: rtl/blk2d_pkg.sv
package blk2d_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BURST   = 2'd1,
        ST_BLK_END = 2'd2,
        ST_FRM_END = 2'd3
    } walk_state_e;

    localparam int LEN_W = 4;

    function automatic logic [LEN_W-1:0] burst_cap(input logic [1:0] code);
        return LEN_W'(1) << code;
    endfunction

endpackage

// File: rtl/blk2d_burst_len.sv
module blk2d_burst_len
    import blk2d_pkg::*;
#(
    parameter int XNUM_W = 10
) (
    input  logic [XNUM_W-1:0] blk_w,
    input  logic [XNUM_W-1:0] word_idx,
    input  logic [1:0]        code,
    output logic [LEN_W-1:0]  len,
    output logic              line_last
);
    logic [XNUM_W-1:0] remaining;
    logic [LEN_W-1:0]  cap;

    always_comb begin
        remaining = blk_w - word_idx;
        cap       = burst_cap(code);
        if (remaining <= XNUM_W'(cap)) begin
            len       = LEN_W'(remaining);
            line_last = 1'b1;
        end else begin
            len       = cap;
            line_last = 1'b0;
        end
    end
endmodule

// File: rtl/blk2d_side_gen.sv
module blk2d_side_gen #(
    parameter int AW  = 28,
    parameter int OW  = 16,
    parameter int XSW = 11,
    parameter int YSW = 14,
    parameter int WW  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  base,
    input  logic [OW-1:0]  stride,
    input  logic [XSW-1:0] xstep,
    input  logic [YSW-1:0] ystep,
    input  logic           next_line,
    input  logic           next_col,
    input  logic           next_row,
    input  logic [WW-1:0]  word_idx,
    output logic [AW-1:0]  addr
);
    localparam int PW = YSW + OW + 1;

    logic signed [PW-1:0] row_prod;
    logic [AW-1:0] row_jump_c, col_jump_c;
    logic [AW-1:0] row_q, blk_q, line_q;
    logic [AW-1:0] stride_q, col_jump_q, row_jump_q;

    assign row_prod   = $signed(ystep) * $signed({1'b0, stride});
    assign row_jump_c = AW'(row_prod);
    assign col_jump_c = AW'($signed(xstep));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q      <= '0;
            blk_q      <= '0;
            line_q     <= '0;
            stride_q   <= '0;
            col_jump_q <= '0;
            row_jump_q <= '0;
        end else if (load) begin
            row_q      <= base;
            blk_q      <= base;
            line_q     <= base;
            stride_q   <= AW'(stride);
            col_jump_q <= col_jump_c;
            row_jump_q <= row_jump_c;
        end else if (next_line) begin
            line_q <= line_q + stride_q;
        end else if (next_col) begin
            blk_q  <= blk_q + col_jump_q;
            line_q <= blk_q + col_jump_q;
        end else if (next_row) begin
            row_q  <= row_q + row_jump_q;
            blk_q  <= row_q + row_jump_q;
            line_q <= row_q + row_jump_q;
        end
    end

    assign addr = line_q + AW'(word_idx);
endmodule

// File: rtl/blk2d_walker.sv
module blk2d_walker
    import blk2d_pkg::*;
#(
    parameter int SYS_AW = 28,
    parameter int LOC_AW = 20,
    parameter int SYS_OW = 16,
    parameter int LOC_OW = 20,
    parameter int XNUM_W = 10,
    parameter int YNUM_W = 13,
    parameter int CNT_W  = 10,
    parameter int XSW    = 11,
    parameter int YSW    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SYS_AW-1:0] cfg_sys_base,
    input  logic [LOC_AW-1:0] cfg_loc_base,
    input  logic [SYS_OW-1:0] cfg_sys_stride,
    input  logic [LOC_OW-1:0] cfg_loc_stride,
    input  logic [XNUM_W-1:0] cfg_blk_w,
    input  logic [YNUM_W-1:0] cfg_blk_h,
    input  logic [CNT_W-1:0]  cfg_cols,
    input  logic [CNT_W-1:0]  cfg_rows,
    input  logic [XSW-1:0]    cfg_xstep,
    input  logic [YSW-1:0]    cfg_ystep,
    input  logic [1:0]        cfg_burst_code,
    input  logic              bst_ready,
    output logic              bst_valid,
    output logic [SYS_AW-1:0] bst_sys_addr,
    output logic [LOC_AW-1:0] bst_loc_addr,
    output logic [3:0]        bst_len,
    output logic              blk_done,
    output logic              frm_done,
    output logic              busy,
    output logic [CNT_W-1:0]  last_bx,
    output logic [CNT_W-1:0]  last_by
);
    walk_state_e state_q, state_d;

    logic [XNUM_W-1:0] blk_w_q, word_q;
    logic [YNUM_W-1:0] blk_h_q, line_q;
    logic [CNT_W-1:0]  cols_q, rows_q, bx_q, by_q;
    logic [1:0]        code_q;

    logic [LEN_W-1:0]  len;
    logic line_last, last_line, col_last, row_last;
    logic load, accept, next_line, next_col, next_row;

    assign load      = (state_q == ST_IDLE) && start;
    assign accept    = (state_q == ST_BURST) && bst_ready;
    assign last_line = (line_q == blk_h_q - YNUM_W'(1));
    assign col_last  = (bx_q == cols_q - CNT_W'(1));
    assign row_last  = (by_q == rows_q - CNT_W'(1));
    assign next_line = accept && line_last && !last_line;
    assign next_col  = (state_q == ST_BLK_END) && !col_last;
    assign next_row  = (state_q == ST_BLK_END) && col_last && !row_last;

    blk2d_burst_len #(.XNUM_W(XNUM_W)) u_len (
        .blk_w     (blk_w_q),
        .word_idx  (word_q),
        .code      (code_q),
        .len       (len),
        .line_last (line_last)
    );

    blk2d_side_gen #(
        .AW(SYS_AW), .OW(SYS_OW), .XSW(XSW), .YSW(YSW), .WW(XNUM_W)
    ) u_sys (
        .clk(clk), .rst_n(rst_n), .load(load),
        .base(cfg_sys_base), .stride(cfg_sys_stride),
        .xstep(cfg_xstep), .ystep(cfg_ystep),
        .next_line(next_line), .next_col(next_col), .next_row(next_row),
        .word_idx(word_q), .addr(bst_sys_addr)
    );

    blk2d_side_gen #(
        .AW(LOC_AW), .OW(LOC_OW), .XSW(XSW), .YSW(YSW), .WW(XNUM_W)
    ) u_loc (
        .clk(clk), .rst_n(rst_n), .load(load),
        .base(cfg_loc_base), .stride(cfg_loc_stride),
        .xstep(cfg_xstep), .ystep(cfg_ystep),
        .next_line(next_line), .next_col(next_col), .next_row(next_row),
        .word_idx(word_q), .addr(bst_loc_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_BURST;
            ST_BURST:   if (accept && line_last && last_line) state_d = ST_BLK_END;
            ST_BLK_END: state_d = (col_last && row_last) ? ST_FRM_END : ST_BURST;
            ST_FRM_END: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_w_q <= '0; blk_h_q <= '0; cols_q <= '0; rows_q <= '0;
            code_q  <= '0; word_q  <= '0; line_q <= '0;
            bx_q    <= '0; by_q    <= '0;
            last_bx <= '0; last_by <= '0;
        end else if (load) begin
            blk_w_q <= cfg_blk_w;
            blk_h_q <= cfg_blk_h;
            cols_q  <= cfg_cols;
            rows_q  <= cfg_rows;
            code_q  <= cfg_burst_code;
            word_q  <= '0;
            line_q  <= '0;
            bx_q    <= '0;
            by_q    <= '0;
            last_bx <= '0;
            last_by <= '0;
        end else if (accept) begin
            if (line_last) begin
                word_q <= '0;
                if (!last_line) begin
                    line_q <= line_q + YNUM_W'(1);
                end else begin
                    last_bx <= bx_q;
                    last_by <= by_q;
                end
            end else begin
                word_q <= word_q + XNUM_W'(len);
            end
        end else if (state_q == ST_BLK_END) begin
            line_q <= '0;
            if (!col_last) begin
                bx_q <= bx_q + CNT_W'(1);
            end else if (!row_last) begin
                bx_q <= '0;
                by_q <= by_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        bst_valid = (state_q == ST_BURST);
        blk_done  = (state_q == ST_BLK_END);
        frm_done  = (state_q == ST_FRM_END);
        busy      = (state_q != ST_IDLE);
        bst_len   = len;
    end
endmodule

// File: rtl/blk2d_walker_chk.sv
module blk2d_walker_chk #(
    parameter int SYS_AW = 28,
    parameter int LOC_AW = 20,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bst_ready,
    input logic              bst_valid,
    input logic [SYS_AW-1:0] bst_sys_addr,
    input logic [LOC_AW-1:0] bst_loc_addr,
    input logic [3:0]        bst_len,
    input logic              blk_done,
    input logic              frm_done,
    input logic              busy,
    input logic [CNT_W-1:0]  last_bx,
    input logic [CNT_W-1:0]  last_by
);
    a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_len != 4'd0 && bst_len <= 4'd8));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_sys_addr)
                                       && $stable(bst_loc_addr) && $stable(bst_len)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_done && bst_valid));

    a_r8_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> $past(blk_done));

    a_r8_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !busy);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (last_bx == '0 && last_by == '0));

    a_r2_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> busy);
endmodule

bind blk2d_walker blk2d_walker_chk #(
    .SYS_AW(SYS_AW), .LOC_AW(LOC_AW), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .bst_ready(bst_ready),
    .bst_valid(bst_valid), .bst_sys_addr(bst_sys_addr),
    .bst_loc_addr(bst_loc_addr), .bst_len(bst_len),
    .blk_done(blk_done), .frm_done(frm_done), .busy(busy),
    .last_bx(last_bx), .last_by(last_by)
);

// File: tb/tb_blk2d_walker.sv
module tb_blk2d_walker;
    localparam int SAW = 28, LAW = 20, SOW = 16, LOW = 20;
    localparam int XW = 10, YW = 13, CW = 10, XSW = 11, YSW = 14;
    localparam longint SMASK = (64'd1 << SAW) - 1;
    localparam longint LMASK = (64'd1 << LAW) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, start, bst_ready;
    logic [SAW-1:0] cfg_sys_base;
    logic [LAW-1:0] cfg_loc_base;
    logic [SOW-1:0] cfg_sys_stride;
    logic [LOW-1:0] cfg_loc_stride;
    logic [XW-1:0]  cfg_blk_w;
    logic [YW-1:0]  cfg_blk_h;
    logic [CW-1:0]  cfg_cols, cfg_rows;
    logic [XSW-1:0] cfg_xstep;
    logic [YSW-1:0] cfg_ystep;
    logic [1:0]     cfg_burst_code;
    logic           bst_valid, blk_done, frm_done, busy;
    logic [SAW-1:0] bst_sys_addr;
    logic [LAW-1:0] bst_loc_addr;
    logic [3:0]     bst_len;
    logic [CW-1:0]  last_bx, last_by;

    blk2d_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_sys_base(cfg_sys_base), .cfg_loc_base(cfg_loc_base),
        .cfg_sys_stride(cfg_sys_stride), .cfg_loc_stride(cfg_loc_stride),
        .cfg_blk_w(cfg_blk_w), .cfg_blk_h(cfg_blk_h),
        .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
        .cfg_xstep(cfg_xstep), .cfg_ystep(cfg_ystep),
        .cfg_burst_code(cfg_burst_code), .bst_ready(bst_ready),
        .bst_valid(bst_valid), .bst_sys_addr(bst_sys_addr),
        .bst_loc_addr(bst_loc_addr), .bst_len(bst_len),
        .blk_done(blk_done), .frm_done(frm_done), .busy(busy),
        .last_bx(last_bx), .last_by(last_by)
    );

    int n_chk = 0, n_fail = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_ready();
        case (rdy_mode)
            0: bst_ready = 1'b1;
            1: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                bst_ready = lfsr[0];
            end
            default: bst_ready = ~bst_ready;
        endcase
    endtask

    task automatic run_frame(input longint sb, input longint lb, input longint so,
                             input longint lo, input int xn, input int yn,
                             input int xc, input int yc, input longint xs,
                             input longint ys, input int code, input bit disturb);
        int inj;
        cfg_sys_base   = SAW'(sb);
        cfg_loc_base   = LAW'(lb);
        cfg_sys_stride = SOW'(so);
        cfg_loc_stride = LOW'(lo);
        cfg_blk_w      = XW'(xn);
        cfg_blk_h      = YW'(yn);
        cfg_cols       = CW'(xc);
        cfg_rows       = CW'(yc);
        cfg_xstep      = XSW'(xs);
        cfg_ystep      = YSW'(ys);
        cfg_burst_code = 2'(code);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(last_bx == 0 && last_by == 0, "R10", "coords cleared", {last_by, last_bx}, 0);
        check(bst_valid == 1'b1 && busy == 1'b1, "R2", "valid after start", bst_valid, 1);
        if (disturb) begin
            cfg_sys_base = '1; cfg_loc_base = '1; cfg_sys_stride = 16'h1234;
            cfg_loc_stride = 20'h55; cfg_blk_w = 10'd7; cfg_blk_h = 13'd9;
            cfg_cols = 10'd5; cfg_rows = 10'd4; cfg_xstep = 11'h3; cfg_ystep = 14'h2;
            cfg_burst_code = 2'd0;
        end
        inj = 0;
        for (int by = 0; by < yc; by++) begin
            for (int bx = 0; bx < xc; bx++) begin
                for (int l = 0; l < yn; l++) begin
                    int w;
                    w = 0;
                    while (w < xn) begin
                        int elen;
                        longint es, el;
                        bit acc, first;
                        string tag;
                        elen = ((1 << code) < (xn - w)) ? (1 << code) : (xn - w);
                        es = (sb + bx * xs + by * ys * so + l * so + w) & SMASK;
                        el = (lb + bx * xs + by * ys * lo + l * lo + w) & LMASK;
                        tag = (w > 0) ? "R4" : ((l > 0) ? "R5" : ((bx == 0 && by == 0) ? "R2" : "R6"));
                        acc = 1'b0;
                        first = 1'b1;
                        while (!acc) begin
                            if (first) begin
                                check(bst_valid && bst_sys_addr == SAW'(es), tag, "sys addr", bst_sys_addr, es);
                                check(bst_valid && bst_loc_addr == LAW'(el), tag, "loc addr", bst_loc_addr, el);
                                check(bst_len == 4'(elen), "R3", "burst length", bst_len, elen);
                            end else begin
                                check(bst_valid && bst_sys_addr == SAW'(es) && bst_loc_addr == LAW'(el)
                                      && bst_len == 4'(elen), "R11", "held burst", bst_sys_addr, es);
                            end
                            drive_ready();
                            start = disturb && (inj % 5 == 2);
                            inj++;
                            acc = bst_ready;
                            first = 1'b0;
                            @(negedge clk);
                        end
                        start = 1'b0;
                        w += elen;
                    end
                end
                check(blk_done && !frm_done && !bst_valid, "R7", "block done pulse", blk_done, 1);
                check(last_bx == CW'(bx) && last_by == CW'(by), "R7", "last coords",
                      {last_by, last_bx}, {by[CW-1:0], bx[CW-1:0]});
                drive_ready();
                @(negedge clk);
            end
        end
        check(frm_done && !blk_done, "R8", "frame done pulse", frm_done, 1);
        @(negedge clk);
        check(!busy && !frm_done && !bst_valid, "R8", "idle after frame", busy, 0);
        if (disturb)
            check(!busy, "R9", "walk unaffected by start and config changes", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; bst_ready = 1'b0;
        cfg_sys_base = '0; cfg_loc_base = '0; cfg_sys_stride = '0; cfg_loc_stride = '0;
        cfg_blk_w = '0; cfg_blk_h = '0; cfg_cols = '0; cfg_rows = '0;
        cfg_xstep = '0; cfg_ystep = '0; cfg_burst_code = '0;
        repeat (3) @(negedge clk);
        check(!bst_valid && !blk_done && !frm_done && !busy, "R1", "reset outputs", busy, 0);
        check(last_bx == 0 && last_by == 0, "R1", "reset coords", {last_by, last_bx}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int code = 0; code < 4; code++) begin
            for (int xn = 1; xn <= 9; xn++) begin
                rdy_mode = xn % 3;
                run_frame(64'h100 + xn, 64'h40, 20, 12, xn, 2, 2, 2, xn, 2, code, xn == 5);
            end
        end
        rdy_mode = 1;
        run_frame(64'h8000, 64'h800, 64, 32, 3, 3, 3, 3, -7, -5, 1, 1'b0);
        rdy_mode = 2;
        run_frame(SMASK - 3, LMASK - 1, 64'hFFFF, 64'hFFFFF, 4, 2, 2, 2, 1023, 8191, 2, 1'b0);
        rdy_mode = 0;
        run_frame(64'h10, 64'h20, 5, 7, 2, 2, 2, 2, -1024, -8192, 3, 1'b0);
        rdy_mode = 1;
        run_frame(64'h2000, 64'h300, 1024, 1024, 1023, 1, 1, 1, 0, 0, 3, 1'b0);
        rdy_mode = 0;
        run_frame(64'h5, 64'h6, 1, 1, 1, 1, 1, 1, 1, 1, 3, 1'b0);
        rdy_mode = 2;
        run_frame(64'h77, 64'h99, 3, 9, 2, 20, 1, 2, 2, 20, 0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule